// File: doc/BRIEF.md
# MSI Write-Back Snoop Controller

This block controls one direct-mapped, write-back cache in a shared-bus multiprocessor. Coherence with the peer caches follows a three-state invalidate protocol: every line is Invalid, Shared or Modified. A load may never grant write permission. Any store to a line that is not Modified must first win a read-for-ownership transaction on the bus, and a store that hits in Shared counts as an upgrade. Hits in Modified, and read hits in Shared, stay local.

The processor side is a valid/ready request channel with a one-cycle response pulse. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. `cpu_req_ready` then stays low until the response has been given, and the processor must take `cpu_rsp_valid` when it arrives.

The bus side raises `bus_req_valid` together with a command, an address and write-back data. These stay on the pins until the bus returns `bus_ack`. Snoops from other caches can still arrive while the request waits. A snoop that changes the line being worked on makes the controller choose its command again on the next cycle. The bus is atomic, so the environment never presents a snoop and an acknowledge in the same cycle.

Snooped transactions come in on `snp_*` and are answered in the same cycle. When the cache holds the block Modified, it raises `snp_flush`, which also tells memory to stay silent, and it drives the line data on `snp_flush_data`.

Command encoding, used both on the request pins and on the snoop pins: 0 = none, 1 = shared read, 2 = read-for-ownership, 3 = write-back. An address splits into an index (its low `IDX_W` bits) and a tag (the remaining bits). Each line holds one word.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, `cpu_req_ready` is high, and neither `bus_req_valid` nor `cpu_rsp_valid` is asserted. No snoop is flushed.
- R2: A read miss issues command 1 at the request address. On `bus_ack` the line is installed Shared with `bus_ack_rdata`, and the same data is returned with `cpu_rsp_valid` on the next cycle.
- R3: A write to a line that is Invalid or Shared, or that holds a different tag, issues command 2 at the request address. On acknowledge the line becomes Modified and holds the write data. A write that hits in Shared still issues command 2.
- R4: Read hits in Shared or Modified, and write hits in Modified, raise no bus request. A read hit returns the stored word.
- R5: A snooped command 1 that matches a Modified line asserts `snp_flush` in the same cycle, with the line data on `snp_flush_data`, and demotes the line to Shared.
- R6: A snooped command 2 that matches a Modified line flushes the data and invalidates the line. If the matching line is Shared, the line is invalidated with no flush.
- R7: A snooped command 1 that matches a Shared line causes no flush and no state change. So does a snoop of command 3, and a snoop whose tag does not match the line.
- R8: A miss whose victim is Modified first issues command 3 with the victim address and data. Only after that acknowledge does it issue command 1 or 2. A Shared victim is dropped silently.
- R9: A pending bus request keeps its command and address until acknowledged. If a snoop removes the Modified victim first, the write-back is not issued.
- R10: `cpu_req_ready` is low from acceptance until after the one-cycle `cpu_rsp_valid` pulse. It is high again when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Controller can accept a request |
| cpu_req_we | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Load data |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | Command code (1 read, 2 read-for-ownership, 3 write-back) |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back data |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_ack_rdata | input | DATA_W | Fill data for read commands |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command code |
| snp_addr | input | ADDR_W | Snooped address |
| snp_flush | output | 1 | This cache supplies the block; memory must not respond |
| snp_flush_data | output | DATA_W | Supplied block data |

## Verification
The assertions check the channel rules on every cycle:
- the response is a single-cycle pulse;
- the controller is not ready while a bus request is pending;
- a flush appears only under a snoop;
- a request holds steady until acknowledged;
- after a write-back the next command is a fill, and a fill acknowledge gives a response on the following cycle.

Which command is correct for a given line state, and what data is flushed and returned, depend on the history of accesses and snoops. Only the bench's scenarios can show these. They cover upgrades from Shared, demotion and invalidation by snoops, dirty and clean eviction, and a snoop that removes a dirty victim while its write-back waits.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LN_I = 2'd0, LN_S = 2'd1, LN_M = 2'd2} line_st_t;
  typedef enum logic [1:0] {CMD_NONE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_WB = 2'd3} bus_cmd_t;
  typedef enum logic [1:0] {FS_IDLE = 2'd0, FS_LOOK = 2'd1, FS_BUS = 2'd2, FS_DONE = 2'd3} fsm_t;
endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  a_idx,
  output line_st_t          a_st,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  input  logic [IDX_W-1:0]  b_idx,
  output line_st_t          b_st,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              w_en,
  input  logic              w_full,
  input  logic [IDX_W-1:0]  w_idx,
  input  line_st_t          w_st,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic [DATA_W-1:0] w_data
);
  localparam int LINES = 1 << IDX_W;

  line_st_t          st_q   [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q[g]   <= LN_I;
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (w_en && (w_idx == IDX_W'(g))) begin
        st_q[g] <= w_st;
        if (w_full) begin
          tag_q[g]  <= w_tag;
          data_q[g] <= w_data;
        end
      end
    end
  end

  assign a_st   = st_q[a_idx];
  assign a_tag  = tag_q[a_idx];
  assign a_data = data_q[a_idx];
  assign b_st   = st_q[b_idx];
  assign b_tag  = tag_q[b_idx];
  assign b_data = data_q[b_idx];
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_t          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              flush,
  output logic [DATA_W-1:0] flush_data,
  output logic              upd,
  output line_st_t          upd_st
);
  logic match;
  assign match = snp_valid && (ln_st != LN_I) && (ln_tag == snp_tag);

  always_comb begin
    flush  = 1'b0;
    upd    = 1'b0;
    upd_st = ln_st;
    if (match) begin
      case (snp_cmd)
        CMD_RD: begin
          if (ln_st == LN_M) begin
            flush  = 1'b1;
            upd    = 1'b1;
            upd_st = LN_S;
          end
        end
        CMD_RDX: begin
          flush  = (ln_st == LN_M);
          upd    = 1'b1;
          upd_st = LN_I;
        end
        default: ;
      endcase
    end
  end

  assign flush_data = flush ? ln_data : '0;
endmodule

// File: rtl/msi_cpu_fsm.sv
module msi_cpu_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_we,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [DATA_W-1:0]         req_wdata,
  output logic                      rsp_valid,
  output logic [DATA_W-1:0]         rsp_rdata,
  input  logic                      snp_busy,
  output logic [IDX_W-1:0]          ln_idx,
  input  line_st_t                  ln_st,
  input  logic [ADDR_W-IDX_W-1:0]   ln_tag,
  input  logic [DATA_W-1:0]         ln_data,
  output logic                      bus_req_valid,
  output logic [1:0]                bus_req_cmd,
  output logic [ADDR_W-1:0]         bus_req_addr,
  output logic [DATA_W-1:0]         bus_req_wdata,
  input  logic                      bus_ack,
  input  logic [DATA_W-1:0]         bus_ack_rdata,
  output logic                      w_en,
  output logic                      w_full,
  output line_st_t                  w_st,
  output logic [ADDR_W-IDX_W-1:0]   w_tag,
  output logic [DATA_W-1:0]         w_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  fsm_t              fs_q;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic [TAG_W-1:0]  tag_q;
  logic              hit;
  logic              victim_dirty;
  logic              look_go;

  assign ln_idx       = addr_q[IDX_W-1:0];
  assign tag_q        = addr_q[ADDR_W-1:IDX_W];
  assign hit          = (ln_st != LN_I) && (ln_tag == tag_q) && (!we_q || ln_st == LN_M);
  assign victim_dirty = (ln_st == LN_M) && (ln_tag != tag_q);
  assign look_go      = (fs_q == FS_LOOK) && !snp_busy;

  assign req_ready     = (fs_q == FS_IDLE);
  assign rsp_valid     = (fs_q == FS_DONE);
  assign rsp_rdata     = rdata_q;
  assign bus_req_valid = (fs_q == FS_BUS);
  assign bus_req_cmd   = victim_dirty ? CMD_WB : (we_q ? CMD_RDX : CMD_RD);
  assign bus_req_addr  = victim_dirty ? {ln_tag, ln_idx} : addr_q;
  assign bus_req_wdata = ln_data;

  always_comb begin
    w_en   = 1'b0;
    w_full = 1'b0;
    w_st   = ln_st;
    w_tag  = tag_q;
    w_data = wdata_q;
    if (look_go && hit && we_q) begin
      w_en   = 1'b1;
      w_full = 1'b1;
      w_st   = LN_M;
    end else if ((fs_q == FS_BUS) && bus_ack) begin
      w_en = 1'b1;
      if (victim_dirty) begin
        w_st = LN_I;
      end else begin
        w_full = 1'b1;
        w_st   = we_q ? LN_M : LN_S;
        w_data = we_q ? wdata_q : bus_ack_rdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q    <= FS_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (fs_q)
        FS_IDLE: if (req_valid) begin
          we_q    <= req_we;
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          fs_q    <= FS_LOOK;
        end
        FS_LOOK: if (look_go) begin
          if (hit) begin
            rdata_q <= ln_data;
            fs_q    <= FS_DONE;
          end else begin
            fs_q <= FS_BUS;
          end
        end
        FS_BUS: if (bus_ack && !victim_dirty) begin
          rdata_q <= bus_ack_rdata;
          fs_q    <= FS_DONE;
        end
        default: fs_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              bus_req_valid,
  output logic [1:0]        bus_req_cmd,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [DATA_W-1:0] bus_req_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_ack_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_flush_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  a_idx;
  line_st_t          a_st, b_st, f_st, s_st, w_st;
  logic [TAG_W-1:0]  a_tag, b_tag, f_tag;
  logic [DATA_W-1:0] a_data, b_data, f_data;
  logic              f_en, f_full, s_upd;

  msi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .b_idx(snp_addr[IDX_W-1:0]), .b_st(b_st), .b_tag(b_tag), .b_data(b_data),
    .w_en(f_en || s_upd), .w_full(f_en && f_full),
    .w_idx(f_en ? a_idx : snp_addr[IDX_W-1:0]),
    .w_st(w_st), .w_tag(f_tag), .w_data(f_data)
  );

  assign w_st = f_en ? f_st : s_st;

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
    .flush(snp_flush), .flush_data(snp_flush_data), .upd(s_upd), .upd_st(s_st)
  );

  msi_cpu_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(cpu_req_valid), .req_ready(cpu_req_ready), .req_we(cpu_req_we),
    .req_addr(cpu_req_addr), .req_wdata(cpu_req_wdata),
    .rsp_valid(cpu_rsp_valid), .rsp_rdata(cpu_rsp_rdata),
    .snp_busy(snp_valid),
    .ln_idx(a_idx), .ln_st(a_st), .ln_tag(a_tag), .ln_data(a_data),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack), .bus_ack_rdata(bus_ack_rdata),
    .w_en(f_en), .w_full(f_full), .w_st(f_st), .w_tag(f_tag), .w_data(f_data)
  );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              bus_req_valid,
  input logic [1:0]        bus_req_cmd,
  input logic [ADDR_W-1:0] bus_req_addr,
  input logic              bus_ack,
  input logic              snp_valid,
  input logic              snp_flush
);
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |=> !cpu_rsp_valid); // R10
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> !cpu_req_ready); // R10
  AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_valid); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_ack && !snp_valid) |=>
      (bus_req_valid && $stable(bus_req_cmd) && $stable(bus_req_addr))); // R9
  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_ack && bus_req_cmd == 2'd3) |=>
      (bus_req_valid && bus_req_cmd != 2'd3)); // R8
  AST_FILL_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && bus_ack && bus_req_cmd != 2'd3) |=> cpu_rsp_valid); // R2
  AST_CMD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> (bus_req_cmd != 2'd0)); // R2
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
  .bus_ack(bus_ack), .snp_valid(snp_valid), .snp_flush(snp_flush)
);

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int IW = 3;

  logic          clk, rst_n;
  logic          cpu_req_valid, cpu_req_ready, cpu_req_we, cpu_rsp_valid;
  logic [AW-1:0] cpu_req_addr, bus_req_addr, snp_addr;
  logic [DW-1:0] cpu_req_wdata, cpu_rsp_rdata, bus_req_wdata, bus_ack_rdata, snp_flush_data;
  logic          bus_req_valid, bus_ack, snp_valid, snp_flush;
  logic [1:0]    bus_req_cmd, snp_cmd;

  msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready), .cpu_req_we(cpu_req_we),
    .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_rdata(cpu_rsp_rdata),
    .bus_req_valid(bus_req_valid), .bus_req_cmd(bus_req_cmd), .bus_req_addr(bus_req_addr),
    .bus_req_wdata(bus_req_wdata), .bus_ack(bus_ack), .bus_ack_rdata(bus_ack_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush), .snp_flush_data(snp_flush_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int m_st [8];
  int m_tag [8];
  logic [31:0] m_data [8];
  logic [31:0] mem [32];

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  endtask

  function automatic string snp_req(int cmd, bit ef);
    if (ef) return (cmd == 1) ? "R5 snoop flush" : "R6 snoop flush";
    return (cmd == 2) ? "R6 snoop" : "R7 snoop";
  endfunction

  // drive at a negedge; checks same-cycle flush; releases after the edge
  task automatic snoop(int cmd, int a);
    int ix, tg;
    bit match, ef;
    ix = a % 8;
    tg = a / 8;
    snp_valid = 1'b1;
    snp_cmd   = 2'(cmd);
    snp_addr  = AW'(a);
    #1;
    match = (m_st[ix] != 0) && (m_tag[ix] == tg);
    ef    = match && (m_st[ix] == 2) && (cmd == 1 || cmd == 2);
    chk(snp_flush == ef, snp_req(cmd, ef), 32'(snp_flush), 32'(ef));
    if (ef) begin
      chk(snp_flush_data == m_data[ix], snp_req(cmd, ef), snp_flush_data, m_data[ix]);
      mem[a] = m_data[ix];
    end
    if (match && cmd == 1 && m_st[ix] == 2) m_st[ix] = 1;
    if (match && cmd == 2) m_st[ix] = 0;
    @(posedge clk);
    #1 snp_valid = 1'b0;
  endtask

  task automatic cpu_op(bit we, int a, logic [31:0] wd, bit inj, int icmd, int ia);
    int ix, tg;
    bit hit, done, injd, saw;
    logic [31:0] erd;
    ix = a % 8;
    tg = a / 8;
    done = 0; injd = 0; saw = 0; erd = '0;
    hit = (m_st[ix] != 0) && (m_tag[ix] == tg) && (!we || m_st[ix] == 2);
    if (hit) begin
      erd = m_data[ix];
      if (we) m_data[ix] = wd;
    end
    @(negedge clk);
    chk(cpu_req_ready == 1'b1, "R10 ready when idle", 32'(cpu_req_ready), 1);
    cpu_req_valid = 1'b1;
    cpu_req_we    = we;
    cpu_req_addr  = AW'(a);
    cpu_req_wdata = wd;
    @(posedge clk);
    #1 cpu_req_valid = 1'b0;
    chk(cpu_req_ready == 1'b0, "R10 busy after accept", 32'(cpu_req_ready), 0);
    for (int k = 0; k < 80 && !done; k++) begin
      @(negedge clk);
      if (cpu_rsp_valid) begin
        done = 1;
        if (!we) chk(cpu_rsp_rdata == erd, hit ? "R4 hit data" : "R2 fill data", cpu_rsp_rdata, erd);
        if (hit) chk(!saw, "R4 no bus on hit", 32'(saw), 0);
        @(posedge clk);
        #1 chk(cpu_rsp_valid == 1'b0, "R10 single pulse", 32'(cpu_rsp_valid), 0);
      end else if (bus_req_valid) begin
        int ecmd, ea;
        string rq;
        saw = 1;
        if (m_st[ix] == 2 && m_tag[ix] != tg) begin
          ecmd = 3; ea = m_tag[ix] * 8 + ix;
        end else begin
          ecmd = we ? 2 : 1; ea = a;
        end
        rq = (ecmd == 3) ? "R8 write-back" : ((ecmd == 2) ? "R3 ownership" : "R2 read miss");
        chk(bus_req_cmd == 2'(ecmd), rq, 32'(bus_req_cmd), 32'(ecmd));
        chk(bus_req_addr == AW'(ea), rq, 32'(bus_req_addr), 32'(ea));
        if (ecmd == 3) chk(bus_req_wdata == m_data[ix], "R8 victim data", bus_req_wdata, m_data[ix]);
        if (inj && !injd) begin
          injd = 1;
          snoop(icmd, ia);
        end else begin
          bus_ack = 1'b1;
          bus_ack_rdata = mem[ea];
          if (ecmd == 3) begin
            mem[ea] = m_data[ix];
            m_st[ix] = 0;
          end else begin
            m_tag[ix] = tg;
            if (we) begin
              m_st[ix] = 2; m_data[ix] = wd;
            end else begin
              m_st[ix] = 1; m_data[ix] = mem[a]; erd = mem[a];
            end
          end
          @(posedge clk);
          #1 bus_ack = 1'b0;
        end
      end
    end
    if (!done) chk(1'b0, "R10 no response", 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog act=running exp=finished");
    summary();
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 8; i++) begin m_st[i] = 0; m_tag[i] = 0; m_data[i] = '0; end
    for (int i = 0; i < 32; i++) mem[i] = 32'h1000_0000 + 32'(i * 17);
    rst_n = 1'b0; cpu_req_valid = 0; cpu_req_we = 0; cpu_req_addr = '0; cpu_req_wdata = '0;
    bus_ack = 0; bus_ack_rdata = '0; snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cpu_req_ready == 1'b1, "R1 ready", 32'(cpu_req_ready), 1);
    chk(bus_req_valid == 1'b0, "R1 bus idle", 32'(bus_req_valid), 0);
    chk(cpu_rsp_valid == 1'b0, "R1 no rsp", 32'(cpu_rsp_valid), 0);
    snoop(1, 5);
    @(negedge clk); snoop(2, 9);
    // R2 read miss, R4 hit, R3 upgrade from S
    cpu_op(0, 3, 0, 0, 0, 0);
    cpu_op(0, 3, 0, 0, 0, 0);
    cpu_op(1, 3, 32'hA5A5_0003, 0, 0, 0);
    cpu_op(0, 3, 0, 0, 0, 0);
    cpu_op(1, 3, 32'hB6B6_0003, 0, 0, 0);
    // R5 demote then R7 no action on S
    @(negedge clk); snoop(1, 3);
    @(negedge clk); snoop(1, 3);
    cpu_op(1, 3, 32'hC7C7_0003, 0, 0, 0);
    // R6 on M then on S
    @(negedge clk); snoop(2, 3);
    cpu_op(0, 3, 0, 0, 0, 0);
    @(negedge clk); snoop(2, 3);
    cpu_op(0, 3, 0, 0, 0, 0);
    // R8 dirty victim then clean victim
    cpu_op(1, 4, 32'hD8D8_0004, 0, 0, 0);
    cpu_op(0, 12, 0, 0, 0, 0);
    cpu_op(0, 4, 0, 0, 0, 0);
    // R9 victim removed by snoop while write-back waits
    cpu_op(1, 6, 32'hE9E9_0006, 0, 0, 0);
    cpu_op(1, 14, 32'hF0F0_000E, 1, 2, 6);
    // R7 snooped write-back ignored
    cpu_op(1, 7, 32'h1234_0007, 0, 0, 0);
    @(negedge clk); snoop(3, 7);
    cpu_op(0, 7, 0, 0, 0, 0);
    for (int n = 0; n < 400; n++) begin
      int r, a;
      r = int'($urandom % 4);
      a = int'($urandom % 32);
      if (r == 0) begin
        @(negedge clk);
        snoop(1 + int'($urandom % 3), a);
      end else begin
        cpu_op(bit'($urandom % 2), a, $urandom, ($urandom % 3) == 0,
               1 + int'($urandom % 2), int'($urandom % 32));
      end
    end
    summary();
  end
endmodule